// File: doc/BRIEF.md
# Resumable Multi-Register Transfer Sequencer

This block walks a 16-bit register mask and moves one register per beat between a register file and memory, as a load-multiple or a store-multiple. Each beat is a single-word request that stays on the memory side until it is acknowledged. The caller supplies a base address and two mode bits. One bit selects the direction (load or store). The other selects incrementing addressing (starting at the base) or decrementing addressing (starting four bytes per listed register below the base), which covers pop-like and push-like transfers.

An interrupt request is looked at only when a beat completes. If it is high then and registers are still left, the sequencer parks. It raises `suspended` and exports the number of the next register in bits [15:12] of a 32-bit status word, with every other bit of that word zero. To resume, the caller starts the sequencer again with the same list, base and mode, with the resume flag set and the saved status word supplied. The sequencer skips every listed register numbered below the saved index, recomputes the address from the registers already moved and finishes the transfer.

Top module: `mrs_seq`

## Requirements
- R1: Listed registers are transferred in ascending register-number order, one per beat. `rf_rd_idx` and `rf_wr_idx` carry the register number of the current beat.
- R2: While `mem_req` is high and `mem_ack` is low, the request stays asserted and `mem_addr` and the register index do not change.
- R3: Beat k (counting from 0 over the whole list) uses address base+4k in increment mode (`dec_mode`=0) and base−4N+4k in decrement mode, where N is the number of set bits in the list.
- R4: `irq` is sampled only in a cycle where a beat is acknowledged. If it is high then and registers remain, the next cycle shows `suspended`=1, no request, and the next register number in `status_out[15:12]`. `irq` in any other cycle has no effect.
- R5: `status_out` bits [26:25] and [11:10] are zero while suspended. The whole word is zero when not suspended.
- R6: A start with `resume`=1 begins at the register in `status_in[15:12]`, skips listed registers below it, and continues the original address sequence.
- R7: If `irq` is high when the last register's beat is acknowledged, the operation completes normally and `suspended` stays 0.
- R8: `done` is high for exactly one cycle, the cycle after the final beat's acknowledge. The block is then idle.
- R9: A start with an empty effective list raises `done` in the next cycle without any memory request.
- R10: On a load, the register-file write strobe is high in the acknowledge cycle with `mem_rdata` as data. On a store, `mem_wdata` equals `rf_rdata` and `mem_we`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or resume) a transfer; accepted when idle or suspended |
| resume | input | 1 | With start: continue from the index in status_in |
| status_in | input | 32 | Saved status word, index in [15:12] |
| reg_list | input | 16 | Register mask, bit i = register i |
| base_addr | input | 32 | Base address |
| is_load | input | 1 | 1 = load from memory, 0 = store |
| dec_mode | input | 1 | 1 = decrementing (start at base−4N) |
| irq | input | 1 | Interrupt request |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Beat completes this cycle |
| mem_rdata | input | 32 | Load data, valid with mem_ack |
| rf_rd_idx | output | 4 | Register read index (store source) |
| rf_rdata | input | 32 | Register read data |
| rf_we | output | 1 | Register write strobe (load) |
| rf_wr_idx | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| busy | output | 1 | A beat is in progress |
| suspended | output | 1 | Continuation state is held |
| done | output | 1 | One-cycle completion pulse |
| status_out | output | 32 | Status word with continuation index |

## Verification
The assertions watch the memory handshake on every cycle. They check that a waiting beat keeps its address and index, that each new beat lies four bytes past the previous one, and that a suspended sequencer issues no request and points at a register still pending. They also check that register writes occur only in load acknowledge cycles and that completion leaves the block idle. Whether the saved index is the right one, whether a resumed transfer lands on the addresses the uninterrupted one would have used, and how an interrupt on the last beat or an empty list behaves can only be shown by the bench's scenarios. The bench compares the whole beat sequence against its own model of the list.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int unsigned LIST_W = 16;
  localparam int unsigned IDX_W  = $clog2(LIST_W);
  localparam int unsigned CNT_W  = IDX_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_SUSP} mrs_state_e;

  // number of set bits in a register mask
  function automatic logic [CNT_W-1:0] f_popcnt(input logic [LIST_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < LIST_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  // lowest set bit position (0 when empty)
  function automatic logic [IDX_W-1:0] f_lowest(input logic [LIST_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LIST_W - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  // mask of all register numbers strictly below idx
  function automatic logic [LIST_W-1:0] f_below(input logic [IDX_W-1:0] idx);
    return (LIST_W'(1) << idx) - LIST_W'(1);
  endfunction
endpackage

// File: rtl/mrs_pick.sv
module mrs_pick
  import mrs_pkg::*;
(
  input  logic [LIST_W-1:0] pending,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [LIST_W-1:0] rest,
  output logic              rest_empty,
  output logic [IDX_W-1:0]  next_idx
);
  logic [LIST_W-1:0] cur_onehot;

  always_comb begin
    cur_idx    = f_lowest(pending);
    cur_onehot = pending & (~pending + LIST_W'(1));
    rest       = pending & ~cur_onehot;
    rest_empty = (rest == '0);
    next_idx   = f_lowest(rest);
  end
endmodule

// File: rtl/mrs_addr_gen.sv
module mrs_addr_gen
  import mrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [LIST_W-1:0] reg_list,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              dec_mode,
  input  logic              resume,
  input  logic [IDX_W-1:0]  resume_idx,
  output logic [LIST_W-1:0] eff_list,
  output logic              eff_empty,
  output logic [ADDR_W-1:0] first_addr
);
  logic [CNT_W-1:0]  total_cnt;
  logic [CNT_W-1:0]  skip_cnt;
  logic [LIST_W-1:0] skip_mask;
  logic [ADDR_W-1:0] origin;

  always_comb begin
    skip_mask  = resume ? f_below(resume_idx) : '0;
    eff_list   = reg_list & ~skip_mask;
    eff_empty  = (eff_list == '0);
    total_cnt  = f_popcnt(reg_list);
    skip_cnt   = f_popcnt(reg_list & skip_mask);
    origin     = dec_mode ? base_addr - (ADDR_W'(total_cnt) << 2) : base_addr;
    first_addr = origin + (ADDR_W'(skip_cnt) << 2);
  end
endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import mrs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAT_W   = 32,
  parameter int unsigned IDX_LSB  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resume,
  input  logic [STAT_W-1:0] status_in,
  input  logic [LIST_W-1:0] reg_list,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              is_load,
  input  logic              dec_mode,
  input  logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              busy,
  output logic              suspended,
  output logic              done,
  output logic [STAT_W-1:0] status_out
);
  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

  mrs_state_e        state_q;
  logic [LIST_W-1:0] pending_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  sav_idx_q;
  logic              load_q;
  logic              done_q;

  // named internal events
  logic              accept_start;
  logic              beat_ack;
  logic              beat_last;
  logic              take_irq;

  logic [IDX_W-1:0]  cur_idx;
  logic [LIST_W-1:0] rest;
  logic              rest_empty;
  logic [IDX_W-1:0]  next_idx;
  logic [LIST_W-1:0] eff_list;
  logic              eff_empty;
  logic [ADDR_W-1:0] first_addr;

  mrs_pick u_pick (
    .pending    (pending_q),
    .cur_idx    (cur_idx),
    .rest       (rest),
    .rest_empty (rest_empty),
    .next_idx   (next_idx)
  );

  mrs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .reg_list   (reg_list),
    .base_addr  (base_addr),
    .dec_mode   (dec_mode),
    .resume     (resume),
    .resume_idx (status_in[IDX_MSB:IDX_LSB]),
    .eff_list   (eff_list),
    .eff_empty  (eff_empty),
    .first_addr (first_addr)
  );

  assign accept_start = start && (state_q != ST_BEAT);
  assign beat_ack     = (state_q == ST_BEAT) && mem_ack;
  assign beat_last    = beat_ack && rest_empty;
  assign take_irq     = beat_ack && !rest_empty && irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      addr_q    <= '0;
      sav_idx_q <= '0;
      load_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_start) begin
        if (eff_empty) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          pending_q <= eff_list;
          addr_q    <= first_addr;
          load_q    <= is_load;
          state_q   <= ST_BEAT;
        end
      end else if (beat_ack) begin
        pending_q <= rest;
        addr_q    <= addr_q + ADDR_W'(4);
        if (beat_last) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else if (take_irq) begin
          sav_idx_q <= next_idx;
          state_q   <= ST_SUSP;
        end
      end
    end
  end

  always_comb begin
    mem_req    = (state_q == ST_BEAT);
    mem_we     = mem_req && !load_q;
    mem_addr   = addr_q;
    mem_wdata  = rf_rdata;
    rf_rd_idx  = cur_idx;
    rf_we      = beat_ack && load_q;
    rf_wr_idx  = cur_idx;
    rf_wdata   = mem_rdata;
    busy       = mem_req;
    suspended  = (state_q == ST_SUSP);
    done       = done_q;
    status_out = '0;
    if (suspended) status_out[IDX_MSB:IDX_LSB] = sav_idx_q;
  end

  // R2: a waiting beat holds its request, address and register
  a_r2_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(rf_rd_idx)));

  // R3: back-to-back beats step the address by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(beat_ack)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));

  // R4: parked sequencer issues nothing and points at a pending register
  a_r4_park_valid: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!mem_req && pending_q[sav_idx_q]));

  // R8: completion leaves the block idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !suspended));

  // R10: register writes only in load acknowledge cycles
  a_r10_rf_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ack && !mem_we));
endmodule

// File: tb/mrs_seq_tb.sv
module mrs_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, resume = 1'b0;
  logic [31:0] status_in = '0;
  logic [15:0] reg_list = '0;
  logic [31:0] base_addr = '0;
  logic        is_load = 1'b0, dec_mode = 1'b0, irq = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we, busy, suspended, done;
  logic [31:0] status_out;
  logic [31:0] rfm [16];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign rf_rdata = rfm[rf_rd_idx];

  mrs_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
    .status_in(status_in), .reg_list(reg_list), .base_addr(base_addr),
    .is_load(is_load), .dec_mode(dec_mode), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rf_rd_idx(rf_rd_idx), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_wr_idx(rf_wr_idx), .rf_wdata(rf_wdata), .busy(busy),
    .suspended(suspended), .done(done), .status_out(status_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int count_bits(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) if (v[i]) c++;
    return c;
  endfunction

  // address of beat k of the full list
  function automatic logic [31:0] beat_addr(input logic [31:0] base, input bit dec,
                                            input int n, input int k);
    logic [31:0] org;
    org = dec ? base - 32'(4 * n) : base;
    return org + 32'(4 * k);
  endfunction

  task automatic run_op(input logic [15:0] list, input logic [31:0] base,
                        input bit ld, input bit dec, input int irq_at);
    int regs[16];
    int n = 0;
    int pos = 0;
    int wait_n;
    logic [31:0] a0, rd;
    for (int i = 0; i < 16; i++) if (list[i]) begin regs[n] = i; n++; end
    @(negedge clk);
    reg_list = list; base_addr = base; is_load = ld; dec_mode = dec;
    resume = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done === 1'b1, "R9 empty list done", 32'(done), 1);
      chk(mem_req === 1'b0, "R9 empty list no request", 32'(mem_req), 0);
      @(negedge clk);
      chk(done === 1'b0, "R8 done single cycle", 32'(done), 0);
      return;
    end
    while (pos < n) begin
      chk(mem_req === 1'b1, "R2 request present", 32'(mem_req), 1);
      a0 = beat_addr(base, dec, n, pos);
      chk(mem_addr === a0, "R3 R6 beat address", mem_addr, a0);
      chk(rf_rd_idx === 4'(regs[pos]), "R1 ascending register", 32'(rf_rd_idx), 32'(regs[pos]));
      wait_n = $urandom_range(0, 2);
      for (int w = 0; w < wait_n; w++) begin
        irq = (pos != irq_at);
        @(negedge clk);
        chk(mem_req === 1'b1 && mem_addr === a0 && suspended === 1'b0,
            "R2 R4 hold while waiting, irq ignored", mem_addr, a0);
      end
      if (!ld) begin
        chk(mem_we === 1'b1, "R10 store write enable", 32'(mem_we), 1);
        chk(mem_wdata === rfm[regs[pos]], "R10 store data", mem_wdata, rfm[regs[pos]]);
      end else begin
        chk(mem_we === 1'b0, "R10 load read", 32'(mem_we), 0);
      end
      rd = $urandom;
      mem_ack = 1'b1; mem_rdata = rd; irq = (pos == irq_at);
      #1;
      if (ld) begin
        chk(rf_we === 1'b1 && rf_wr_idx === 4'(regs[pos]), "R10 load write strobe/index",
            32'(rf_wr_idx), 32'(regs[pos]));
        chk(rf_wdata === rd, "R10 load data", rf_wdata, rd);
      end else begin
        chk(rf_we === 1'b0, "R10 no register write on store", 32'(rf_we), 0);
      end
      @(negedge clk);
      mem_ack = 1'b0; irq = 1'b0;
      pos++;
      if (pos == n) begin
        chk(done === 1'b1, "R8 R7 done after final beat", 32'(done), 1);
        chk(suspended === 1'b0 && busy === 1'b0, "R7 no suspension at end", 32'(suspended), 0);
        @(negedge clk);
        chk(done === 1'b0, "R8 done single cycle", 32'(done), 0);
      end else if (pos - 1 == irq_at) begin
        chk(suspended === 1'b1 && mem_req === 1'b0, "R4 suspended, no request",
            32'(suspended), 1);
        chk(status_out[15:12] === 4'(regs[pos]), "R4 continuation index",
            32'(status_out[15:12]), 32'(regs[pos]));
        chk(status_out[26:25] === 2'b00 && status_out[11:10] === 2'b00,
            "R5 reserved status bits zero", status_out, {16'h0, 4'(regs[pos]), 12'h0});
        for (int w = 0; w < 3; w++) @(negedge clk);
        chk(suspended === 1'b1 && done === 1'b0, "R4 stays parked", 32'(suspended), 1);
        status_in = status_out;
        start = 1'b1; resume = 1'b1;
        @(negedge clk);
        start = 1'b0; resume = 1'b0;
        chk(suspended === 1'b0, "R5 R6 resumed, not suspended", 32'(suspended), 0);
        chk(status_out === 32'h0, "R5 status cleared when running", status_out, 0);
      end else begin
        chk(suspended === 1'b0, "R4 no suspension without irq at ack", 32'(suspended), 0);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) rfm[i] = 32'hA500_0000 + 32'(i * 32'h111);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req === 1'b0 && busy === 1'b0, "R2 reset no request", 32'(mem_req), 0);
    chk(done === 1'b0 && suspended === 1'b0, "R8 reset idle", 32'(done), 0);
    chk(status_out === 32'h0, "R5 reset status zero", status_out, 0);

    // directed corner cases
    run_op(16'h0000, 32'h1000, 1, 0, -1);       // R9
    run_op(16'hFFFF, 32'h2000, 1, 0, 0);        // R4 R6 early suspend, load inc
    run_op(16'h8001, 32'h3000, 0, 1, 0);        // R6 skip to 15, store dec
    run_op(16'h0F0F, 32'h4000, 0, 1, 7);        // R7 irq on last beat
    run_op(16'h0040, 32'h5000, 1, 1, 0);        // R7 single register with irq
    run_op(16'hA5A5, 32'h6000, 0, 0, -1);       // R1 R3 no interrupt
    run_op(16'h7FFE, 32'h7000, 1, 1, 12);       // R4 late suspend

    // constrained random
    for (int t = 0; t < 40; t++) begin
      logic [15:0] l;
      int nb, ia;
      l = 16'($urandom);
      if (t % 9 == 0) l = 16'(1) << $urandom_range(0, 15);
      nb = count_bits(l);
      ia = (nb == 0) ? -1 : int'($urandom_range(0, nb)) - 1;
      run_op(l, 32'h0001_0000 + 32'({$urandom_range(0, 255), 4'h0}),
             1'($urandom), 1'($urandom), ia);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule